// File: doc/BRIEF.md
# DMA Address Translation Unit

This unit sits in a bus bridge and turns 32-bit DMA virtual addresses from devices into 43-bit physical addresses. Translation uses a page table held in system memory. A small register interface holds a control word and the table base. Each accepted device request is first checked against the mapped window. That window always ends at the top of the 32-bit space, and its size follows a 3-bit table-size code. For an address inside the window the unit fetches one 64-bit table entry over a simple memory request/response port. It checks the entry's valid bit, and for writes also the writeable bit. It then returns either a physical address or a fault.

When the enable bit is clear, the unit is a pass-through. The virtual address comes back unchanged as the physical address and no table read is made. Only one request is handled at a time. The unit is busy from acceptance until its response pulse.

The controller has four states. `ST_IDLE` accepts a request. It moves to `ST_DONE` directly for bypass or for a window miss, and otherwise to `ST_FETCH`. `ST_FETCH` holds the memory request and moves to `ST_WAIT` on `mem_req_ready`. `ST_WAIT` waits for `mem_rsp_valid`, checks the entry and moves to `ST_DONE`. `ST_DONE` pulses the response for one cycle and returns to `ST_IDLE`.

Top module: `dvma_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and both configuration words read back as zero.
- R2: A write with `cfg_addr`=0 stores the control word and a write with `cfg_addr`=1 stores the table base. In the control word, bit 0 is enable, bit 1 is diagnostic, bit 2 is large-page select and bits 18:16 are the size code; all other bits read back as zero. The table base keeps bits 42:13 only; bits 12:0 and 63:43 read back as zero.
- R3: With enable clear, an accepted request gets `rsp_valid` in the next cycle with `rsp_pa` equal to the zero-extended virtual address, `rsp_fault`=0, and no memory request.
- R4: With enable set, the window base is 0xFFFFFFFF shifted left by (code+23), truncated to 32 bits. An address below the base faults with no memory request.
- R5: For an in-window address, exactly one memory request is issued at address {base[42:13],13'b0} + ((va − window base) >> 13) × 8.
- R6: An entry whose bit 63 is clear gives a fault.
- R7: A write request to an entry whose bit 1 is clear gives a fault; a read of the same entry does not.
- R8: A successful translation returns {entry[42:13], va[12:0]}. Entry bits 12:7, 61, 60 and 4 have no effect on the result.
- R9: Every faulting response carries `rsp_pa` = 0.
- R10: `req_ready` is 1 only while idle. `rsp_valid` is a one-cycle pulse. `mem_req_valid` stays high with a stable address until `mem_req_ready`.
- R11: The diagnostic and large-page control bits do not change the translation; 8K pages are always used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = control word, 1 = table base |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Readback of the selected configuration word |
| req_valid | input | 1 | Device request valid |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_va | input | 32 | DMA virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation fault |
| rsp_pa | output | 43 | Physical address (zero on fault) |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 43 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
An FSM state that is stuck or skipped shows at the ports within one or two cycles of acceptance. Possible symptoms are a missing or doubled `rsp_valid` pulse, `req_ready` high while a fetch is outstanding, or a memory request for a bypassed address. A corrupted captured address or entry address shows on `mem_req_addr` in the first fetch cycle. A corrupted page offset or permission flag shows only on the response itself, one cycle after the entry arrives. The bench therefore compares the fetch address, the fault flag and the physical address for every request.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 43;
    localparam int PG_SHIFT = 13;
    localparam int ENT_W    = 64;
    localparam int CODE_W   = 3;
    localparam int TBL_LOG0 = 10;   // log2 entries at code 0
    localparam int ENT_VLD  = 63;
    localparam int ENT_WR   = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } xl_state_e;
endpackage

// File: rtl/dvma_regs.sv
module dvma_regs
    import dvma_pkg::*;
#(
    parameter int PA_BITS = PA_W,
    parameter int PG_BITS = PG_SHIFT,
    parameter int CW      = CODE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_addr,
    input  logic [63:0]            cfg_wdata,
    output logic [63:0]            cfg_rdata,
    output logic                   ctl_en,
    output logic [CW-1:0]          ctl_code,
    output logic [PA_BITS-PG_BITS-1:0] tbl_page
);
    localparam int CODE_LSB = 16;

    logic ctl_diag, ctl_pg64;
    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_diag <= 1'b0;
            ctl_pg64 <= 1'b0;
            ctl_code <= '0;
            tbl_page <= '0;
        end else if (cfg_we) begin
            if (!cfg_addr) begin
                ctl_en   <= cfg_wdata[0];
                ctl_diag <= cfg_wdata[1];
                ctl_pg64 <= cfg_wdata[2];
                ctl_code <= cfg_wdata[CODE_LSB +: CW];
            end else begin
                tbl_page <= cfg_wdata[PA_BITS-1:PG_BITS];
            end
        end
    end

    always_comb begin
        if (!cfg_addr)
            cfg_rdata = 64'({ctl_code, (CODE_LSB-3)'(0), ctl_pg64, ctl_diag, ctl_en});
        else
            cfg_rdata = 64'({tbl_page, PG_BITS'(0)});
    end

    AST_CFG_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_addr |=> ctl_en == $past(cfg_wdata[0])); // R2
endmodule

// File: rtl/dvma_window.sv
module dvma_window
    import dvma_pkg::*;
#(
    parameter int VA_BITS = VA_W,
    parameter int PA_BITS = PA_W,
    parameter int PG_BITS = PG_SHIFT,
    parameter int CW      = CODE_W,
    parameter int E_BITS  = ENT_W
) (
    input  logic [CW-1:0]              code,
    input  logic [PA_BITS-PG_BITS-1:0] tbl_page,
    input  logic [VA_BITS-1:0]         va,
    output logic                       hit,
    output logic [PA_BITS-1:0]         ent_addr
);
    localparam int ENT_SHIFT = $clog2(E_BITS / 8);
    localparam int SLOT_W    = VA_BITS - PG_BITS;

    logic [5:0]         sh;
    logic [VA_BITS-1:0] win_base;
    logic [VA_BITS-1:0] offs;
    logic [SLOT_W-1:0]  slot;

    always_comb begin
        sh       = 6'(code) + 6'(TBL_LOG0 + PG_BITS);
        win_base = {VA_BITS{1'b1}} << sh;
        hit      = (va >= win_base);
        offs     = va - win_base;
        slot     = offs[VA_BITS-1:PG_BITS];
        ent_addr = {tbl_page, PG_BITS'(0)} + PA_BITS'({slot, ENT_SHIFT'(0)});
    end
endmodule

// File: rtl/dvma_fsm.sv
module dvma_fsm
    import dvma_pkg::*;
#(
    parameter int VA_BITS = VA_W,
    parameter int PA_BITS = PA_W,
    parameter int PG_BITS = PG_SHIFT,
    parameter int E_BITS  = ENT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_BITS-1:0] req_va,
    input  logic               req_write,
    input  logic               xl_en,
    input  logic               win_hit,
    input  logic [PA_BITS-1:0] win_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_BITS-1:0] rsp_pa,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [E_BITS-1:0]  mem_rsp_data
);
    xl_state_e          st, st_nxt;
    logic [PG_BITS-1:0] va_lo_q;
    logic               wr_q;
    logic [PA_BITS-1:0] addr_q;
    logic [PA_BITS-1:0] pa_q;
    logic               fault_q;
    logic               accept, ent_bad;
    logic               unused_ent;

    assign accept     = (st == ST_IDLE) && req_valid;
    assign ent_bad    = !mem_rsp_data[ENT_VLD] || (wr_q && !mem_rsp_data[ENT_WR]);
    assign unused_ent = ^mem_rsp_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nxt = (!xl_en || !win_hit) ? ST_DONE : ST_FETCH;
            ST_FETCH: if (mem_req_ready) st_nxt = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_nxt = ST_DONE;
            ST_DONE:  st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // captured request and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_lo_q <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else if (accept) begin
            va_lo_q <= req_va[PG_BITS-1:0];
            wr_q    <= req_write;
            addr_q  <= win_addr;
            if (!xl_en) begin
                pa_q    <= PA_BITS'(req_va);
                fault_q <= 1'b0;
            end else if (!win_hit) begin
                pa_q    <= '0;
                fault_q <= 1'b1;
            end
        end else if (st == ST_WAIT && mem_rsp_valid) begin
            fault_q <= ent_bad;
            pa_q    <= ent_bad ? '0 : {mem_rsp_data[PA_BITS-1:PG_BITS], va_lo_q};
        end
    end

    // outputs
    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_FETCH);
        rsp_valid     = (st == ST_DONE);
        mem_req_addr  = addr_q;
        rsp_pa        = pa_q;
        rsp_fault     = fault_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready); // R10
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == '0); // R9
    AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !xl_en |=> rsp_valid && !rsp_fault && !mem_req_valid); // R3
    AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R5
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
    import dvma_pkg::*;
#(
    parameter int VA_BITS = VA_W,
    parameter int PA_BITS = PA_W,
    parameter int PG_BITS = PG_SHIFT,
    parameter int CW      = CODE_W,
    parameter int E_BITS  = ENT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [63:0]        cfg_wdata,
    output logic [63:0]        cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_BITS-1:0] req_va,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_BITS-1:0] rsp_pa,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [E_BITS-1:0]  mem_rsp_data
);
    logic                       en;
    logic [CW-1:0]              code;
    logic [PA_BITS-PG_BITS-1:0] tbl_page;
    logic                       hit;
    logic [PA_BITS-1:0]         ent_addr;

    dvma_regs #(.PA_BITS(PA_BITS), .PG_BITS(PG_BITS), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctl_en(en), .ctl_code(code), .tbl_page(tbl_page)
    );

    dvma_window #(.VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .PG_BITS(PG_BITS),
                  .CW(CW), .E_BITS(E_BITS)) u_window (
        .code(code), .tbl_page(tbl_page), .va(req_va),
        .hit(hit), .ent_addr(ent_addr)
    );

    dvma_fsm #(.VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .PG_BITS(PG_BITS),
               .E_BITS(E_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .xl_en(en), .win_hit(hit), .win_addr(ent_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );
endmodule

// File: tb/dvma_xlate_bench.sv
`timescale 1ns/1ps
module dvma_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [42:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [42:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int vectors = 0;
    int miscompares = 0;

    logic        cur_en;
    logic [2:0]  cur_code;
    logic [42:0] cur_tbl;

    always #2 clk = ~clk;

    dvma_xlate u_dvma_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] win_base(input logic [2:0] c);
        return 32'hFFFF_FFFF << (c + 23);
    endfunction

    task automatic cfg_write(input logic a, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic a, output logic [63:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic setup(input logic en, input logic diag, input logic pg, input logic [2:0] code,
                         input logic [42:0] tbl);
        cfg_write(1'b0, {45'd0, code, 13'd0, pg, diag, en});
        cfg_write(1'b1, {21'h1FFFFF, tbl});
        cur_en = en; cur_code = code; cur_tbl = {tbl[42:13], 13'd0};
    endtask

    task automatic run(input logic [31:0] va, input logic wr, input logic [63:0] ent,
                       output logic f, output logic [42:0] pa,
                       output logic fetched, output logic [42:0] faddr);
        bit done = 0;
        int phase = 0;
        int dly = 0;
        f = 1'b0; pa = '0; fetched = 1'b0; faddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !done; i++) begin
            if (rsp_valid) begin
                f = rsp_fault; pa = rsp_pa; done = 1;
                mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
            end else begin
                if (phase == 0) begin
                    if (mem_req_ready) begin
                        mem_req_ready = 1'b0; phase = 1; dly = $urandom % 3;
                    end else if (mem_req_valid) begin
                        if (!fetched) begin
                            fetched = 1'b1; faddr = mem_req_addr;
                        end else begin
                            chk("R10 fetch address held", {21'd0, mem_req_addr}, {21'd0, faddr});
                        end
                        if ($urandom % 3 != 0) mem_req_ready = 1'b1;
                    end
                end else if (phase == 1) begin
                    if (mem_rsp_valid) begin
                        mem_rsp_valid = 1'b0; phase = 2;
                    end else if (dly == 0) begin
                        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
                    end else begin
                        dly--;
                    end
                end else begin
                    if (mem_req_valid) chk("R5 single fetch", 64'd1, 64'd0);
                end
                @(negedge clk);
            end
        end
        if (!done) chk("R10 response timeout", 64'd0, 64'd1);
        @(negedge clk);
        chk("R10 one-cycle pulse and idle", {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    task automatic apply(input string tag, input logic [31:0] va, input logic wr, input logic [63:0] ent);
        logic f, fe, ef, efe;
        logic [42:0] pa, fa, epa, efa;
        logic [31:0] wb;
        wb = win_base(cur_code);
        efa = '0;
        if (!cur_en) begin
            ef = 1'b0; epa = {11'd0, va}; efe = 1'b0;
        end else if (va < wb) begin
            ef = 1'b1; epa = '0; efe = 1'b0;
        end else begin
            efe = 1'b1;
            efa = cur_tbl + 43'({(va - wb) >> 13, 3'b000});
            if (!ent[63] || (wr && !ent[1])) begin
                ef = 1'b1; epa = '0;
            end else begin
                ef = 1'b0; epa = {ent[42:13], va[12:0]};
            end
        end
        run(va, wr, ent, f, pa, fe, fa);
        chk({tag, " fault"}, {63'd0, f}, {63'd0, ef});
        chk({tag, " pa"}, {21'd0, pa}, {21'd0, epa});
        chk({tag, " fetch issued"}, {63'd0, fe}, {63'd0, efe});
        if (efe && fe) chk({tag, " fetch addr"}, {21'd0, fa}, {21'd0, efa});
    endtask

    initial begin
        logic [63:0] rd;
        logic [63:0] e;
        logic [31:0] va;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R1 no response/fetch", {62'd0, rsp_valid, mem_req_valid}, 64'd0);
        cfg_read(1'b0, rd); chk("R1 ctrl reset", rd, 64'd0);
        cfg_read(1'b1, rd); chk("R1 base reset", rd, 64'd0);

        // R2 readback masks
        cfg_write(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_read(1'b0, rd); chk("R2 ctrl mask", rd, 64'h0000_0000_0007_0007);
        cfg_write(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_read(1'b1, rd); chk("R2 base mask", rd, 64'h0000_07FF_FFFF_E000);

        // R3 bypass
        setup(1'b0, 1'b0, 1'b0, 3'd0, 43'h123_4567_8000);
        apply("R3 bypass", 32'h1234_5678, 1'b0, 64'h8000_0000_0000_0002);
        apply("R3 bypass write", 32'hFFFF_FFFF, 1'b1, 64'd0);

        // R4/R5 window edges, code 0
        setup(1'b1, 1'b0, 1'b0, 3'd0, 43'h000_4000_0000);
        apply("R4 below window code0", 32'hFF7F_FFFF, 1'b0, 64'h8000_0000_0000_0002);
        apply("R5 first slot code0", 32'hFF80_0000, 1'b0, 64'h8000_0012_3456_0002);
        // code 7, last slot
        setup(1'b1, 1'b0, 1'b0, 3'd7, 43'h7AB_CDE0_0000);
        apply("R5 last slot code7", 32'hFFFF_FFFF, 1'b1, 64'h8000_0555_5555_E002);
        apply("R4 below window code7", 32'hBFFF_FFFF, 1'b0, 64'h8000_0000_0000_0002);
        apply("R5 base slot code7", 32'hC000_1234, 1'b0, 64'h8000_0000_0000_2000);

        // R6 / R7 / R9
        apply("R6 invalid entry", 32'hD000_0000, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
        apply("R7 write to readonly", 32'hD000_2000, 1'b1, 64'h8000_0000_1234_6000);
        apply("R7 read of readonly", 32'hD000_2000, 1'b0, 64'h8000_0000_1234_6000);
        apply("R9 fault pa zero", 32'hE000_0000, 1'b1, 64'h0000_07FF_FFFF_E000);

        // R8 ignored entry bits
        apply("R8 plain entry", 32'hF000_1ABC, 1'b0, 64'h8000_0000_ABCD_E002);
        apply("R8 sw/stream/large/cache bits set", 32'hF000_1ABC, 1'b0, 64'hB000_0000_ABCD_FF92);

        // R11 diag and large-page bits
        setup(1'b1, 1'b1, 1'b1, 3'd2, 43'h001_0000_0000);
        apply("R11 diag+large still 8K", 32'hFE00_3FFF, 1'b0, 64'h8000_0001_0000_2002);

        // random
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0)
                setup(($urandom % 6) != 0, $urandom % 2, $urandom % 2, 3'($urandom % 8),
                      {11'($urandom), $urandom});
            e = {$urandom, $urandom};
            e[63] = ($urandom % 5) != 0;
            va = $urandom;
            if ($urandom % 4 != 0) va = win_base(cur_code) | (va & ~win_base(cur_code));
            apply("R5/R8 random", va, $urandom % 2, e);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R10 act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule